// File: doc/BRIEF.md
# Saturating Bit Node Accumulator

This block performs the variable-node update of a min-sum LDPC decoder for a single bit node. A start pulse loads the 6-bit channel value. After that, a serial stream of check-to-bit messages is accumulated, one per valid beat. Every operand arrives in sign-magnitude form. The block converts each one to two's complement and adds it into a 9-bit running sum that saturates. The beat marked last closes the frame. One cycle later the block presents the total, clipped to the 6-bit message range and converted back to sign-magnitude, together with the hard-decision bit.

Once a frame is closed, the decoder can request the extrinsic message for any edge. It presents that edge's own check message, and one cycle later it receives the clipped total minus that message, again clipped and in sign-magnitude. The block holds the total until the next frame closes, so requests for all edges can be issued back to back.

Top module: `bit_node_acc`

## Requirements
- R1: A cycle with `frameStart` high loads the running sum with the two's-complement value of `chanIn` and discards anything left from the previous frame; a message beat in the same cycle is not added.
- R2: Each cycle with `msgValid` high, and `frameStart` low, adds the value of `msgIn` to the running sum. Cycles with `msgValid` low leave the sum unchanged, whatever `msgIn` and `msgLast` carry.
- R3: All messages use a 6-bit sign-magnitude code: bit 5 is the sign (1 = negative) and bits 4:0 are the magnitude. The input 6'b100000 is read as zero. The outputs `sumOut` and `extOut` never carry 6'b100000.
- R4: `hardBit` is 0 when the clipped total is zero or positive and 1 when it is negative.
- R5: `sumValid` is high for exactly one cycle: the cycle after a beat with both `msgValid` and `msgLast` high. `sumOut` and `hardBit` keep that frame's result until the next frame closes.
- R6: After every addition the running sum saturates to the 9-bit range -255..+255. The reported total is that sum clipped to -31..+31.
- R7: A cycle with `extReq` high produces, on the next cycle, `extValid` high and `extOut` equal to the clipped total minus the value of `extMsgIn`, clipped to -31..+31 and coded as in R3.
- R8: After reset, `sumValid` and `extValid` are low, `sumOut` is 6'b000000 and `hardBit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Loads the channel value and begins a frame |
| chanIn | input | 6 | Channel value, sign-magnitude |
| msgValid | input | 1 | Message beat strobe |
| msgLast | input | 1 | Marks the final beat of the frame |
| msgIn | input | 6 | Check-to-bit message, sign-magnitude |
| extReq | input | 1 | Requests one extrinsic message |
| extMsgIn | input | 6 | The edge's own check message, sign-magnitude |
| sumValid | output | 1 | One-cycle strobe: total is ready |
| sumOut | output | 6 | Clipped total, sign-magnitude |
| hardBit | output | 1 | Hard decision: 1 when the total is negative |
| extValid | output | 1 | Extrinsic result is valid |
| extOut | output | 6 | Extrinsic message, sign-magnitude |

## Verification
The assertions assume the following input discipline:
- `frameStart` and `msgValid` are never high in the same cycle.
- Each frame ends with exactly one `msgLast` beat.
- No message beat arrives before the first start after reset.

The stimulus keeps to this rule. Every frame begins with a lone start cycle, and its final valid beat is the only one carrying `msgLast`. Idle gaps inside a frame carry random message and last bits with `msgValid` low, which exercises R2 without breaking the framing. Extrinsic requests are issued only after a frame has closed.

// File: rtl/bit_node_pkg.sv
package bit_node_pkg;
  parameter int MsgW = 6;
  parameter int AccW = 9;
  localparam int MagW = MsgW - 1;
  localparam int PadW = AccW - MagW;

  typedef logic [MsgW-1:0] smT;
  typedef logic signed [AccW-1:0] accT;
  typedef logic signed [AccW:0] wideT;

  localparam accT AccPos = accT'((2 ** (AccW - 1)) - 1);
  localparam accT MagPos = accT'((2 ** MagW) - 1);

  typedef struct packed {
    logic load;
    logic add;
    logic close;
    logic extReq;
  } ctrlStrobesT;

  function automatic accT smToTc(smT m);
    accT magExt;
    magExt = accT'({{PadW{1'b0}}, m[MagW-1:0]});
    return m[MsgW-1] ? -magExt : magExt;
  endfunction

  function automatic accT satAdd(accT a, accT b);
    wideT s;
    s = wideT'(a) + wideT'(b);
    if (s > wideT'(AccPos)) return AccPos;
    if (s < -wideT'(AccPos)) return -AccPos;
    return s[AccW-1:0];
  endfunction

  function automatic accT clipMag(accT v);
    if (v > MagPos) return MagPos;
    if (v < -MagPos) return -MagPos;
    return v;
  endfunction

  function automatic smT tcToSm(accT v);
    accT a;
    a = (v < 0) ? -v : v;
    return {(v < 0), a[MagW-1:0]};
  endfunction
endpackage

// File: rtl/bit_node_ctrl.sv
module bit_node_ctrl
  import bit_node_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        msgValid,
  input  logic        msgLast,
  input  logic        extReq,
  output ctrlStrobesT st,
  output logic        sumValid,
  output logic        extValid
);
  always_comb begin
    st.load   = frameStart;
    st.add    = msgValid && !frameStart;
    st.close  = msgValid && msgLast && !frameStart;
    st.extReq = extReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumValid <= 1'b0;
      extValid <= 1'b0;
    end else begin
      sumValid <= st.close;
      extValid <= st.extReq;
    end
  end

  // R5: result strobe exactly one cycle after the closing beat
  assert_sum_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgLast && !frameStart) |=> sumValid);
  // R5: no strobe without a closing beat
  assert_sum_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(msgValid && msgLast && !frameStart) |=> !sumValid);
  // R7: extrinsic result follows each request
  assert_ext_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    extReq |=> extValid);
endmodule

// File: rtl/bit_node_dp.sv
module bit_node_dp
  import bit_node_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobesT st,
  input  smT          chanIn,
  input  smT          msgIn,
  input  smT          extMsgIn,
  output smT          sumOut,
  output logic        hardBit,
  output smT          extOut
);
  accT accReg, accNext, totalReg, extDiff;
  smT  extReg;

  always_comb begin
    accNext = accReg;
    if (st.load)     accNext = smToTc(chanIn);
    else if (st.add) accNext = satAdd(accReg, smToTc(msgIn));
    extDiff = clipMag(satAdd(totalReg, -smToTc(extMsgIn)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg   <= '0;
      totalReg <= '0;
      extReg   <= '0;
    end else begin
      accReg <= accNext;
      if (st.close)  totalReg <= clipMag(accNext);
      if (st.extReq) extReg   <= tcToSm(extDiff);
    end
  end

  assign sumOut  = tcToSm(totalReg);
  assign hardBit = totalReg[AccW-1];
  assign extOut  = extReg;

  // R1: a start cycle loads the channel value
  assert_load_chan_R1: assert property (@(posedge clk) disable iff (!rstN)
    st.load |=> accReg == $past(smToTc(chanIn)));
  // R2: idle cycles keep the running sum
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!st.load && !st.add) |=> $stable(accReg));
  // R3: no negative zero on the total
  assert_no_negzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    sumOut != {1'b1, {(MsgW-1){1'b0}}});
  // R3: no negative zero on the extrinsic output
  assert_ext_negzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    extOut != {1'b1, {(MsgW-1){1'b0}}});
  // R4: hard decision agrees with the sign of the coded total
  assert_hard_sign_R4: assert property (@(posedge clk) disable iff (!rstN)
    hardBit == sumOut[MsgW-1]);
  // R6: running sum never leaves the symmetric 9-bit range
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accReg <= AccPos) && (accReg >= -AccPos));
endmodule

// File: rtl/bit_node_acc.sv
module bit_node_acc
  import bit_node_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic [5:0] chanIn,
  input  logic       msgValid,
  input  logic       msgLast,
  input  logic [5:0] msgIn,
  input  logic       extReq,
  input  logic [5:0] extMsgIn,
  output logic       sumValid,
  output logic [5:0] sumOut,
  output logic       hardBit,
  output logic       extValid,
  output logic [5:0] extOut
);
  ctrlStrobesT st;

  bit_node_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .msgValid(msgValid),
    .msgLast(msgLast), .extReq(extReq), .st(st), .sumValid(sumValid),
    .extValid(extValid)
  );

  bit_node_dp uDp (
    .clk(clk), .rstN(rstN), .st(st), .chanIn(chanIn), .msgIn(msgIn),
    .extMsgIn(extMsgIn), .sumOut(sumOut), .hardBit(hardBit), .extOut(extOut)
  );
endmodule

// File: tb/bit_node_acc_test.sv
module bit_node_acc_test;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, msgValid = 1'b0, msgLast = 1'b0, extReq = 1'b0;
  logic [5:0] chanIn = '0, msgIn = '0, extMsgIn = '0;
  logic sumValid, hardBit, extValid;
  logic [5:0] sumOut, extOut;

  int testCnt = 0;
  int failCnt = 0;
  bit doneFlag = 1'b0;
  logic [5:0] msgs [0:23];

  always #(ClkPeriod/2) clk = ~clk;

  bit_node_acc uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .chanIn(chanIn),
    .msgValid(msgValid), .msgLast(msgLast), .msgIn(msgIn), .extReq(extReq),
    .extMsgIn(extMsgIn), .sumValid(sumValid), .sumOut(sumOut),
    .hardBit(hardBit), .extValid(extValid), .extOut(extOut)
  );

  function automatic int tcOf(logic [5:0] m);
    return m[5] ? -int'(m[4:0]) : int'(m[4:0]);
  endfunction

  function automatic int clip(int v, int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic logic [5:0] smOf(int v);
    int a;
    a = (v < 0) ? -v : v;
    return {(v < 0), a[4:0]};
  endfunction

  task automatic chk(string tag, int act, int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Runs one frame of n messages; gaps inserts idle beats carrying junk.
  task automatic runFrame(logic [5:0] chan, int n, bit gaps);
    int acc, total;
    @(negedge clk);
    frameStart = 1'b1; chanIn = chan; msgValid = 1'b0; msgLast = 1'b0;
    acc = tcOf(chan);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frameStart = 1'b0;
      if (gaps && ($urandom % 3 == 0)) begin
        msgValid = 1'b0; msgIn = 6'($urandom); msgLast = 1'($urandom);
        @(negedge clk);
      end
      msgValid = 1'b1; msgIn = msgs[i]; msgLast = (i == n - 1);
      acc = clip(acc + tcOf(msgs[i]), 255);
    end
    total = clip(acc, 31);
    @(negedge clk);
    msgValid = 1'b0; msgLast = 1'b0;
    chk("R5 sumValid after last beat", int'(sumValid), 1);
    chk("R6 R3 clipped total", int'(sumOut), int'(smOf(total)));
    chk("R4 hard decision", int'(hardBit), (total < 0) ? 1 : 0);
    @(negedge clk);
    chk("R5 sumValid single pulse", int'(sumValid), 0);
    chk("R5 total held", int'(sumOut), int'(smOf(total)));
    for (int i = 0; i < n; i++) begin
      extReq = 1'b1; extMsgIn = msgs[i];
      @(negedge clk);
      extReq = 1'b0;
      chk("R7 extValid", int'(extValid), 1);
      chk("R7 extrinsic value", int'(extOut),
          int'(smOf(clip(total - tcOf(msgs[i]), 31))));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R8 sumValid after reset", int'(sumValid), 0);
    chk("R8 extValid after reset", int'(extValid), 0);
    chk("R8 sumOut after reset", int'(sumOut), 0);
    chk("R8 hardBit after reset", int'(hardBit), 0);
    rstN = 1'b1;

    // R6: all positive maximum, accumulator saturates at +255
    for (int i = 0; i < 12; i++) msgs[i] = 6'b011111;
    runFrame(6'b011111, 12, 1'b0);
    // R4: all negative maximum
    for (int i = 0; i < 12; i++) msgs[i] = 6'b111111;
    runFrame(6'b111111, 12, 1'b0);
    // R3: negative zeros everywhere give a plain zero
    for (int i = 0; i < 4; i++) msgs[i] = 6'b100000;
    runFrame(6'b100000, 4, 1'b0);
    // R4: exact cancellation to zero reads as non-negative
    msgs[0] = 6'b100011; msgs[1] = 6'b100010;
    runFrame(6'b000101, 2, 1'b0);
    // R6: saturation order matters: 9 x +31 then 8 x -31 gives 7
    for (int i = 0; i < 9; i++) msgs[i] = 6'b011111;
    for (int i = 9; i < 17; i++) msgs[i] = 6'b111111;
    runFrame(6'b011111, 17, 1'b0);
    // R1: a new start discards the previous frame; R2: gaps with junk
    msgs[0] = 6'b000001;
    runFrame(6'b100100, 1, 1'b1);
    // R2 R7: random frames with idle gaps
    for (int f = 0; f < 40; f++) begin
      int n;
      n = 1 + int'($urandom % 12);
      for (int i = 0; i < n; i++) msgs[i] = 6'($urandom);
      runFrame(6'($urandom), n, 1'b1);
    end

    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule